// File: doc/BRIEF.md
# Smartcard Waiting Time Watchdog

This block watches the I/O line of an ISO 7816 smartcard interface and reports when the card has stayed silent too long. It counts card clock strobes in coarse ticks. One tick is twelve ETUs long. Any falling edge on the I/O line, which marks the start bit of a character, restarts the window. Halfway through the window it emits a one-cycle warning pulse. When the window runs out it emits a one-cycle expiry pulse.

After expiry the counter parks. It stays enabled, and the next falling edge on the line re-arms it. Software-style enable and disable strobes start and stop supervision. The clocks-per-ETU and waiting-time values are programmable. Writing either one recomputes both the tick period and the number of ticks the window allows. The I/O input may be asynchronous, because it passes through a two-flop synchroniser first.

Top module: `sc_wait_watchdog`

## Requirements
- R1: After reset, clocks per ETU is 372 and the waiting time is 9600 ETUs. Both pulse outputs and running_o are low, and the counter is stopped.
- R2: A tick lasts clocks_per_etu*12 strobes of clk_en_i. Cycles where clk_en_i is low do not advance the counter.
- R3: The window allows A = waiting_time/12 ticks (integer division). A result of 0 is treated as 1. The expiry pulse is high for exactly one cycle, following the edge that sees the A*P-th strobe after the start, where P is the tick length. running_o falls in that same cycle.
- R4: The half pulse is high for exactly one cycle when the tick count reaches A/2. It is never emitted when A/2 is 0.
- R5: enable_i clears the tick count and the cycle counter, and starts counting. running_o is high in the cycle after the enable edge. Strobes begin to count from the next edge.
- R6: disable_i stops the counter and clears it, and it has priority over enable_i. While disabled, falling edges on io_i are ignored and running_o stays low.
- R7: After expiry the block stays parked until a falling edge on io_i. That edge takes effect on the third rising clock edge after io_i falls, and it restarts a full window.
- R8: A falling edge on io_i while counting clears the tick count and the cycle counter. The window then restarts from that edge.
- R9: If a falling edge and a tick boundary fall on the same edge, the falling edge wins. No tick is counted, and no half pulse is emitted.
- R10: A write of either configuration value takes effect from the next edge. The tick period and the allowed tick count both follow the new values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| clk_en_i | input | 1 | One strobe per card clock cycle |
| io_i | input | 1 | Card I/O line, asynchronous |
| enable_i | input | 1 | Clear and start counting |
| disable_i | input | 1 | Clear and stop counting |
| etu_we_i | input | 1 | Load clocks-per-ETU value |
| etu_val_i | input | 16 | New clocks-per-ETU value |
| wt_we_i | input | 1 | Load waiting-time value |
| wt_val_i | input | 16 | New waiting time in ETUs |
| half_o | output | 1 | Half of the window elapsed (one cycle) |
| expired_o | output | 1 | Window elapsed (one cycle) |
| running_o | output | 1 | Counter active |

## Verification
The bench builds the block with its default widths. It sweeps clocks-per-ETU from 1 to 3 and the waiting time over values from 0 to 100. That gives windows of a few hundred strobes, so every configuration's half and expiry points can be measured strobe by strobe. It repeats the sweep with a strobe on every other cycle. The small periods also let it land an I/O falling edge exactly on a tick boundary. Each reset default is checked separately, by reprogramming only the other value so the window stays short enough to run.

// File: rtl/sc_wdt_pkg.sv
package sc_wdt_pkg;
  parameter int unsigned VAL_W    = 16;
  parameter int unsigned TICK_ETU = 12;
  parameter int unsigned PER_W    = VAL_W + 4;
  parameter logic [VAL_W-1:0] ETU_RST = 16'd372;
  parameter logic [VAL_W-1:0] WT_RST  = 16'd9600;
endpackage

// File: rtl/sc_io_fall.sv
module sc_io_fall (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic io_i,
  output logic fall_o
);
  logic [2:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 3'b111;
    else         sync_q <= {sync_q[1:0], io_i};
  end

  assign fall_o = sync_q[2] & ~sync_q[1];
endmodule

// File: rtl/sc_wdt_cfg.sv
module sc_wdt_cfg
  import sc_wdt_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             etu_we_i,
  input  logic [VAL_W-1:0] etu_val_i,
  input  logic             wt_we_i,
  input  logic [VAL_W-1:0] wt_val_i,
  output logic [PER_W-1:0] period_o,
  output logic [VAL_W-1:0] allowed_o,
  output logic [VAL_W-1:0] half_lim_o
);
  logic [VAL_W-1:0] etu_q, wt_q, ticks_raw;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      etu_q <= ETU_RST;
      wt_q  <= WT_RST;
    end else begin
      if (etu_we_i) etu_q <= etu_val_i;
      if (wt_we_i)  wt_q  <= wt_val_i;
    end
  end

  assign period_o   = PER_W'(etu_q) * PER_W'(TICK_ETU);
  assign ticks_raw  = wt_q / VAL_W'(TICK_ETU);
  assign allowed_o  = (ticks_raw == '0) ? VAL_W'(1) : ticks_raw;
  assign half_lim_o = allowed_o >> 1;
endmodule

// File: rtl/sc_wdt_engine.sv
module sc_wdt_engine
  import sc_wdt_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clk_en_i,
  input  logic             fall_i,
  input  logic             enable_i,
  input  logic             disable_i,
  input  logic [PER_W-1:0] period_i,
  input  logic [VAL_W-1:0] allowed_i,
  input  logic [VAL_W-1:0] half_lim_i,
  output logic             half_o,
  output logic             expired_o,
  output logic             running_o
);
  logic             en_q, run_q, half_q, exp_q;
  logic [PER_W-1:0] cyc_q;
  logic [VAL_W-1:0] ticks_q, ticks_nx;
  logic             wrap;

  assign ticks_nx = ticks_q + VAL_W'(1);
  // >= so that a shortened period wraps at once
  assign wrap     = ({1'b0, cyc_q} + (PER_W+1)'(1)) >= {1'b0, period_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= 1'b0;
      run_q   <= 1'b0;
      half_q  <= 1'b0;
      exp_q   <= 1'b0;
      cyc_q   <= '0;
      ticks_q <= '0;
    end else begin
      half_q <= 1'b0;
      exp_q  <= 1'b0;
      if (disable_i) begin
        en_q    <= 1'b0;
        run_q   <= 1'b0;
        cyc_q   <= '0;
        ticks_q <= '0;
      end else if (enable_i) begin
        en_q    <= 1'b1;
        run_q   <= 1'b1;
        cyc_q   <= '0;
        ticks_q <= '0;
      end else if (fall_i && en_q) begin
        run_q   <= 1'b1;
        cyc_q   <= '0;
        ticks_q <= '0;
      end else if (run_q && clk_en_i) begin
        if (wrap) begin
          cyc_q   <= '0;
          ticks_q <= ticks_nx;
          if (ticks_nx == half_lim_i) half_q <= 1'b1;
          if (ticks_nx >= allowed_i) begin
            run_q <= 1'b0;
            exp_q <= 1'b1;
          end
        end else begin
          cyc_q <= cyc_q + PER_W'(1);
        end
      end
    end
  end

  assign half_o    = half_q;
  assign expired_o = exp_q;
  assign running_o = run_q;

  assert_stop_on_disable_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    disable_i |=> !run_q);
  assert_parked_after_expiry_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exp_q |-> !run_q);
  assert_pulses_exclusive_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(half_q && exp_q));
  assert_half_while_running_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    half_q |-> run_q);
  assert_expiry_single_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exp_q |=> !exp_q);
  assert_edge_rearms_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fall_i && en_q && !disable_i) |=> run_q);
  assert_enable_starts_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_i && !disable_i) |=> (run_q && ticks_q == '0));
endmodule

// File: rtl/sc_wait_watchdog.sv
module sc_wait_watchdog
  import sc_wdt_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clk_en_i,
  input  logic             io_i,
  input  logic             enable_i,
  input  logic             disable_i,
  input  logic             etu_we_i,
  input  logic [VAL_W-1:0] etu_val_i,
  input  logic             wt_we_i,
  input  logic [VAL_W-1:0] wt_val_i,
  output logic             half_o,
  output logic             expired_o,
  output logic             running_o
);
  logic             fall;
  logic [PER_W-1:0] period;
  logic [VAL_W-1:0] allowed, half_lim;

  sc_io_fall i_io_fall (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .io_i   (io_i),
    .fall_o (fall)
  );

  sc_wdt_cfg i_cfg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .etu_we_i   (etu_we_i),
    .etu_val_i  (etu_val_i),
    .wt_we_i    (wt_we_i),
    .wt_val_i   (wt_val_i),
    .period_o   (period),
    .allowed_o  (allowed),
    .half_lim_o (half_lim)
  );

  sc_wdt_engine i_engine (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clk_en_i   (clk_en_i),
    .fall_i     (fall),
    .enable_i   (enable_i),
    .disable_i  (disable_i),
    .period_i   (period),
    .allowed_i  (allowed),
    .half_lim_i (half_lim),
    .half_o     (half_o),
    .expired_o  (expired_o),
    .running_o  (running_o)
  );
endmodule

// File: tb/test_sc_wait_watchdog.sv
module test_sc_wait_watchdog;
  logic clk = 1'b0, rst_n = 1'b0;
  logic clk_en = 1'b0, io = 1'b1, ena = 1'b0, dis = 1'b0;
  logic etu_we = 1'b0, wt_we = 1'b0;
  logic [15:0] etu_val = '0, wt_val = '0;
  logic half, expd, running;
  int n_chk = 0, n_fail = 0;
  bit gap = 0;

  always #10 clk = ~clk;

  sc_wait_watchdog i_sc_wait_watchdog (
    .clk_i(clk), .rst_ni(rst_n), .clk_en_i(clk_en), .io_i(io),
    .enable_i(ena), .disable_i(dis), .etu_we_i(etu_we), .etu_val_i(etu_val),
    .wt_we_i(wt_we), .wt_val_i(wt_val), .half_o(half), .expired_o(expd),
    .running_o(running)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; clk_en = 1'b0; ena = 1'b0; dis = 1'b0; io = 1'b1;
    tick(); tick(); rst_n = 1'b1; tick(); tick(); tick();
  endtask

  task automatic wr_etu(input int v);
    etu_val = 16'(v); etu_we = 1'b1; tick(); etu_we = 1'b0;
  endtask

  task automatic wr_wt(input int v);
    wt_val = 16'(v); wt_we = 1'b1; tick(); wt_we = 1'b0;
  endtask

  // pulses enable, then counts strobes until expiry; records strobe index of each pulse
  task automatic run_window(input int limit, output int half_at, output int exp_at,
                            output int n_half, output int n_exp);
    int s = 0;
    half_at = -1; exp_at = -1; n_half = 0; n_exp = 0;
    clk_en = 1'b0; ena = 1'b1; tick(); ena = 1'b0;
    for (int c = 0; c < 2 * limit + 8; c++) begin
      clk_en = gap ? ~clk_en : 1'b1;
      if (clk_en) s++;
      tick();
      if (half) begin n_half++; if (half_at < 0) half_at = s; end
      if (expd) begin n_exp++; if (exp_at < 0) exp_at = s; end
      if (exp_at >= 0 && s > exp_at + 3) break;
    end
    clk_en = 1'b0;
  endtask

  initial begin
    int ha, ea, nh, ne, a, p;
    do_reset();
    chk(!half && !expd && !running, "R1 reset outputs", {half, expd, running}, 0);

    // R1: waiting-time default (9600) with etu=1: window 800 ticks of 12
    wr_etu(1);
    run_window(9600, ha, ea, nh, ne);
    chk(ea == 9600, "R1 default waiting time expiry", ea, 9600);
    chk(ha == 4800, "R1 default half point", ha, 4800);
    // R1: etu default (372) with wt=12: one tick of 4464
    do_reset();
    wr_wt(12);
    run_window(4464, ha, ea, nh, ne);
    chk(ea == 4464, "R1 default etu expiry", ea, 4464);
    chk(nh == 0, "R4 no half when A/2 is 0", nh, 0);

    // R2 R3 R4 R10 sweep, strobe each cycle then every other cycle
    for (int g = 0; g < 2; g++) begin
      gap = (g == 1);
      for (int e = 1; e <= 3; e++) begin
        for (int w = 0; w <= 100; w += 11) begin
          wr_etu(e); wr_wt(w);
          p = 12 * e; a = (w / 12 == 0) ? 1 : w / 12;
          run_window(a * p, ha, ea, nh, ne);
          chk(ea == a * p, "R2 R3 expiry strobe index", ea, a * p);
          chk(ne == 1, "R3 single expiry pulse", ne, 1);
          chk(!running, "R3 running low after expiry", running, 0);
          if (a / 2 >= 1) begin
            chk(ha == (a / 2) * p, "R4 half strobe index", ha, (a / 2) * p);
            chk(nh == 1, "R4 single half pulse", nh, 1);
          end else chk(nh == 0, "R4 no half pulse", nh, 0);
        end
      end
    end
    gap = 0;

    // R7: parked, re-armed on third edge after io falls
    wr_etu(1); wr_wt(48);
    run_window(48, ha, ea, nh, ne);
    for (int c = 0; c < 20; c++) begin clk_en = 1'b1; tick(); end
    chk(!running && !expd, "R7 stays parked", running, 0);
    clk_en = 1'b0;
    io = 1'b0; tick(); tick();
    chk(!running, "R7 not yet rearmed after 2 edges", running, 0);
    tick();
    chk(running, "R7 rearmed on 3rd edge", running, 1);
    begin
      int s = 0; ea = -1;
      for (int c = 0; c < 60; c++) begin
        clk_en = 1'b1; s++; tick();
        if (expd && ea < 0) ea = s;
      end
      chk(ea == 48, "R7 full window after rearm", ea, 48);
    end
    clk_en = 1'b0; io = 1'b1; tick(); tick(); tick();

    // R8: restart while counting (P=12, A=4)
    begin
      int s = 0; ea = -1; ha = -1;
      clk_en = 1'b0; ena = 1'b1; tick(); ena = 1'b0;
      for (int c = 0; c < 70; c++) begin
        clk_en = 1'b1; s++;
        if (c == 5) io = 1'b0;
        tick();
        if (expd && ea < 0) ea = s;
        if (half && ha < 0) ha = s;
      end
      // edge acts on edge c=7 (strobe 8); counting resumes after it
      chk(ea == 8 + 48, "R8 expiry after restart", ea, 56);
      chk(ha == 8 + 24, "R8 half after restart", ha, 32);
    end
    clk_en = 1'b0; io = 1'b1; tick(); tick(); tick();

    // R9: edge on tick boundary, A=2 so half_lim=1
    wr_wt(24);
    begin
      int s = 0; ea = -1; ha = -1;
      clk_en = 1'b0; ena = 1'b1; tick(); ena = 1'b0;
      for (int c = 0; c < 60; c++) begin
        clk_en = 1'b1; s++;
        if (c == 9) io = 1'b0; // acts on strobe 12, the first boundary
        tick();
        if (expd && ea < 0) ea = s;
        if (half && ha < 0) ha = s;
      end
      chk(ha == 24, "R9 edge wins, half delayed", ha, 24);
      chk(ea == 36, "R9 edge wins, expiry delayed", ea, 36);
    end
    clk_en = 1'b0; io = 1'b1; tick(); tick(); tick();

    // R6: disable stops, falling edges ignored
    ena = 1'b1; tick(); ena = 1'b0;
    for (int c = 0; c < 5; c++) begin clk_en = 1'b1; tick(); end
    dis = 1'b1; ena = 1'b1; tick(); dis = 1'b0; ena = 1'b0;
    chk(!running, "R6 disable wins over enable", running, 0);
    io = 1'b0;
    begin
      int ne2 = 0;
      for (int c = 0; c < 80; c++) begin tick(); if (expd || running) ne2++; end
      chk(ne2 == 0, "R6 edge and strobes ignored while disabled", ne2, 0);
    end
    io = 1'b1; clk_en = 1'b0; tick(); tick(); tick();
    chk(!running, "R6 still stopped", running, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #3000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog timeout actual=1 expected=0");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule